// File: doc/BRIEF.md
# Sequence-Guarded Watchdog Timer

This block is a watchdog timer that is already armed and counting when reset is released. A 32-bit counter counts up from a programmable load value, advancing once for each cycle in which the `tick` enable is high. When it passes its all-ones value, the block sends a single-cycle system reset request, reloads the counter and keeps counting. Firmware prevents this by writing to a service register, which reloads the counter, or by stopping the watchdog.

Stopping the watchdog takes an ordered two-word handshake on a control register. A similar handshake starts it again. Each control write takes a fixed number of cycles to take effect. While that write is in flight, a pending flag in the status register is set and further control writes are dropped. Firmware must poll the flag and wait for it to clear before it sends the second word.

Top module: `wdog_top`

## Requirements
- R1: After reset the counter and the load register both read 0xFFFF0000, the watchdog is enabled, `wdt_rst_req` is low and the status register reads 0.
- R2: While the watchdog is enabled, the counter at offset 0x28 rises by one on each clock where `tick` is high, and it holds on each clock where `tick` is low.
- R3: A write to the control register at offset 0x48 sets bit 4 of the status register at offset 0x34 for exactly 4 clock cycles. The write takes effect on the edge at which the bit clears.
- R4: Writing 0x0000AAAA and then 0x00005555 to the control register stops the watchdog, and the counter then holds its value.
- R5: If 0x0000AAAA is followed by any value other than 0x00005555, the handshake is cancelled and the watchdog keeps running. A lone 0x00005555 has no effect.
- R6: Writing 0x0000BBBB and then 0x00004444 to the control register starts the watchdog. On the edge where the second word takes effect, the counter is reloaded from the load register at offset 0x2C.
- R7: A control write made while status bit 4 is set is dropped. It neither advances the handshake nor changes the value read back from the control register.
- R8: When the counter is at 0xFFFFFFFF and a tick arrives, `wdt_rst_req` is high for exactly one cycle, the counter reloads from the load register, and counting continues.
- R9: Any write to the service register at offset 0x30 reloads the counter from the load register on the next edge.
- R10: The load register can be read and written. The control register reads back the last accepted write. Reads of unmapped offsets return 0, and writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick | input | 1 | Count enable: the counter advances on each clock where this is high |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from `bus_addr` |
| wdt_rst_req | output | 1 | Single-cycle system reset request on expiry |

## Verification
The hardest case to reach is a control write that lands inside the pending window of an earlier one. Its loss can only be seen afterwards, through the handshake state. The bench sends 0xAAAA and then sends 0x5555 two cycles later, while the first write is still pending. It then checks that the watchdog still runs and that the control register still reads 0xAAAA. A properly paced 0x5555 after that must stop the counter, which shows that the armed state survived the dropped write. Expiry is reached quickly by loading 0xFFFFFFF0 and servicing the timer, which makes the reset pulse land exactly 16 cycles later.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Register byte offsets
  localparam logic [7:0] OFS_COUNT = 8'h28;
  localparam logic [7:0] OFS_LOAD  = 8'h2C;
  localparam logic [7:0] OFS_KICK  = 8'h30;
  localparam logic [7:0] OFS_STAT  = 8'h34;
  localparam logic [7:0] OFS_CTRL  = 8'h48;

  // Status bit that flags an in-flight control write
  localparam int STAT_PEND_BIT = 4;

  // Handshake words
  localparam logic [31:0] KEY_OFF_A = 32'h0000_AAAA;
  localparam logic [31:0] KEY_OFF_B = 32'h0000_5555;
  localparam logic [31:0] KEY_ON_A  = 32'h0000_BBBB;
  localparam logic [31:0] KEY_ON_B  = 32'h0000_4444;

  typedef enum logic [1:0] {
    SEQ_IDLE      = 2'd0,
    SEQ_OFF_ARMED = 2'd1,
    SEQ_ON_ARMED  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] LOAD_RST = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] cnt_val,
  input  logic [DATA_W-1:0] ctrl_val,
  input  logic              pend,
  output logic [DATA_W-1:0] load_val,
  output logic              ctrl_wr,
  output logic              kick_wr,
  output logic [DATA_W-1:0] rdata
);

  logic              hit_count, hit_load, hit_kick, hit_stat, hit_ctrl;
  logic              load_en;
  logic [DATA_W-1:0] load_q, load_n;
  logic [DATA_W-1:0] stat_word;

  // Address decode
  always_comb begin
    hit_count = (bus_addr == ADDR_W'(OFS_COUNT));
    hit_load  = (bus_addr == ADDR_W'(OFS_LOAD));
    hit_kick  = (bus_addr == ADDR_W'(OFS_KICK));
    hit_stat  = (bus_addr == ADDR_W'(OFS_STAT));
    hit_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
  end

  // Write strobes
  always_comb begin
    ctrl_wr = bus_we && hit_ctrl;
    kick_wr = bus_we && hit_kick;
    load_en = bus_we && hit_load;
    load_n  = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= DATA_W'(LOAD_RST);
    end else if (load_en) begin
      load_q <= load_n;
    end
  end

  assign load_val = load_q;

  always_comb begin
    stat_word                = '0;
    stat_word[STAT_PEND_BIT] = pend;
  end

  // Read mux
  always_comb begin
    rdata = '0;
    if (hit_count) rdata = cnt_val;
    if (hit_load)  rdata = load_q;
    if (hit_stat)  rdata = stat_word;
    if (hit_ctrl)  rdata = ctrl_val;
  end

endmodule

// File: rtl/wdog_sync.sv
module wdog_sync #(
  parameter int DATA_W      = 32,
  parameter int SYNC_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              pend,
  output logic [DATA_W-1:0] ctrl_val,
  output logic              apply,
  output logic [DATA_W-1:0] apply_val
);

  localparam int PW = $clog2(SYNC_CYCLES + 1);

  logic [PW-1:0]     pcnt_q, pcnt_n;
  logic              pcnt_en;
  logic [DATA_W-1:0] val_q, val_n;
  logic              val_en;
  logic              accept;

  // Next state
  always_comb begin
    accept  = ctrl_wr && (pcnt_q == '0);
    pcnt_n  = pcnt_q;
    pcnt_en = 1'b0;
    val_n   = val_q;
    val_en  = 1'b0;
    if (accept) begin
      pcnt_n  = PW'(SYNC_CYCLES);
      pcnt_en = 1'b1;
      val_n   = wdata;
      val_en  = 1'b1;
    end else if (pcnt_q != '0) begin
      pcnt_n  = pcnt_q - PW'(1);
      pcnt_en = 1'b1;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else if (pcnt_en) begin
      pcnt_q <= pcnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (val_en) begin
      val_q <= val_n;
    end
  end

  assign pend      = (pcnt_q != '0);
  assign apply     = (pcnt_q == PW'(1));
  assign ctrl_val  = val_q;
  assign apply_val = val_q;

endmodule

// File: rtl/wdog_seq.sv
module wdog_seq
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              apply,
  input  logic [DATA_W-1:0] apply_val,
  output logic              enable,
  output logic              reload
);

  seq_state_e st_q, st_n;
  logic       en_q, en_n;
  logic       is_off_a, is_off_b, is_on_a, is_on_b;

  always_comb begin
    is_off_a = (apply_val == DATA_W'(KEY_OFF_A));
    is_off_b = (apply_val == DATA_W'(KEY_OFF_B));
    is_on_a  = (apply_val == DATA_W'(KEY_ON_A));
    is_on_b  = (apply_val == DATA_W'(KEY_ON_B));
  end

  // Next state
  always_comb begin
    st_n   = st_q;
    en_n   = en_q;
    reload = 1'b0;
    if (apply) begin
      case (st_q)
        SEQ_IDLE: begin
          if (is_off_a)     st_n = SEQ_OFF_ARMED;
          else if (is_on_a) st_n = SEQ_ON_ARMED;
          else              st_n = SEQ_IDLE;
        end
        SEQ_OFF_ARMED: begin
          st_n = SEQ_IDLE;
          if (is_off_b) en_n = 1'b0;
        end
        SEQ_ON_ARMED: begin
          st_n = SEQ_IDLE;
          if (is_on_b) begin
            en_n   = 1'b1;
            reload = 1'b1;
          end
        end
        default: st_n = SEQ_IDLE;
      endcase
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SEQ_IDLE;
      en_q <= 1'b1;
    end else if (apply) begin
      st_q <= st_n;
      en_q <= en_n;
    end
  end

  assign enable = en_q;

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int          DATA_W   = 32,
  parameter logic [31:0] LOAD_RST = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              enable,
  input  logic              reload,
  input  logic              kick,
  input  logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] cnt,
  output logic              rst_req
);

  localparam logic [DATA_W-1:0] CNT_MAX = '1;

  logic [DATA_W-1:0] cnt_q, cnt_n;
  logic              cnt_en;
  logic              req_q, req_n;

  // Next state
  always_comb begin
    cnt_n  = cnt_q;
    cnt_en = 1'b0;
    req_n  = 1'b0;
    if (reload || kick) begin
      cnt_n  = load_val;
      cnt_en = 1'b1;
    end else if (enable && tick) begin
      cnt_en = 1'b1;
      if (cnt_q == CNT_MAX) begin
        cnt_n = load_val;
        req_n = 1'b1;
      end else begin
        cnt_n = cnt_q + DATA_W'(1);
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= DATA_W'(LOAD_RST);
    end else if (cnt_en) begin
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_n;
    end
  end

  assign cnt     = cnt_q;
  assign rst_req = req_q;

endmodule

// File: rtl/wdog_top.sv
module wdog_top #(
  parameter int          ADDR_W      = 8,
  parameter int          SYNC_CYCLES = 4,
  parameter logic [31:0] LOAD_RST    = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              wdt_rst_req
);

  localparam int DATA_W = 32;

  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic [DATA_W-1:0] cnt, load_val, ctrl_val, apply_val;
  logic              pend, ctrl_wr, kick_wr, apply, enable, reload;

  // Reset: asserts at once, releases on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_n_int = rst_sync_q[1];

  wdog_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .LOAD_RST (LOAD_RST)
  ) i_regs (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt_val   (cnt),
    .ctrl_val  (ctrl_val),
    .pend      (pend),
    .load_val  (load_val),
    .ctrl_wr   (ctrl_wr),
    .kick_wr   (kick_wr),
    .rdata     (bus_rdata)
  );

  wdog_sync #(
    .DATA_W      (DATA_W),
    .SYNC_CYCLES (SYNC_CYCLES)
  ) i_sync (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .ctrl_wr   (ctrl_wr),
    .wdata     (bus_wdata),
    .pend      (pend),
    .ctrl_val  (ctrl_val),
    .apply     (apply),
    .apply_val (apply_val)
  );

  wdog_seq #(
    .DATA_W (DATA_W)
  ) i_seq (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .apply     (apply),
    .apply_val (apply_val),
    .enable    (enable),
    .reload    (reload)
  );

  wdog_count #(
    .DATA_W   (DATA_W),
    .LOAD_RST (LOAD_RST)
  ) i_count (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .tick     (tick),
    .enable   (enable),
    .reload   (reload),
    .kick     (kick_wr),
    .load_val (load_val),
    .cnt      (cnt),
    .rst_req  (wdt_rst_req)
  );

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
  import wdog_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_CYCLES = 4
) (
  input logic              clk,
  input logic              rst_n_int,
  input logic              tick,
  input logic              enable,
  input logic              reload,
  input logic              kick_wr,
  input logic              ctrl_wr,
  input logic              pend,
  input logic [31:0]       ctrl_val,
  input logic [31:0]       cnt,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              wdt_rst_req
);

  localparam int RW = $clog2(SYNC_CYCLES + 2);

  logic [RW-1:0] pend_run;
  logic          unmapped;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)  pend_run <= '0;
    else if (pend)   pend_run <= pend_run + RW'(1);
    else             pend_run <= '0;
  end

  always_comb begin
    unmapped = (bus_addr != ADDR_W'(OFS_COUNT)) && (bus_addr != ADDR_W'(OFS_LOAD)) &&
               (bus_addr != ADDR_W'(OFS_STAT))  && (bus_addr != ADDR_W'(OFS_CTRL));
  end

  // R3: the pending window lasts exactly SYNC_CYCLES cycles
  a_r3_pend_len: assert property (@(posedge clk) disable iff (!rst_n_int)
    $fell(pend) |-> (pend_run == RW'(SYNC_CYCLES)));

  // R2: without tick, service or reload the counter holds
  a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!tick && !kick_wr && !reload) |=> $stable(cnt));

  // R4: a stopped watchdog does not count
  a_r4_stopped_frozen: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!enable && !kick_wr && !reload) |=> $stable(cnt));

  // R7: control writes during the pending window are dropped
  a_r7_drop_pending: assert property (@(posedge clk) disable iff (!rst_n_int)
    (ctrl_wr && pend) |=> $stable(ctrl_val));

  // R8: a reset request follows the counter's all-ones value
  a_r8_req_after_max: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(wdt_rst_req) |-> ($past(cnt) == 32'hFFFF_FFFF));

  // R10: unmapped offsets read zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n_int)
    unmapped |-> (bus_rdata == 32'h0));

endmodule

bind wdog_top wdog_chk #(
  .ADDR_W      (ADDR_W),
  .SYNC_CYCLES (SYNC_CYCLES)
) i_chk (
  .clk         (clk),
  .rst_n_int   (rst_n_int),
  .tick        (tick),
  .enable      (enable),
  .reload      (reload),
  .kick_wr     (kick_wr),
  .ctrl_wr     (ctrl_wr),
  .pend        (pend),
  .ctrl_val    (ctrl_val),
  .cnt         (cnt),
  .bus_addr    (bus_addr),
  .bus_rdata   (bus_rdata),
  .wdt_rst_req (wdt_rst_req)
);

// File: tb/test_wdog_top.sv
`timescale 1ns/1ps
module test_wdog_top;

  logic        clk;
  logic        rst_n;
  logic        tick;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        wdt_rst_req;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  localparam logic [7:0] A_CNT  = 8'h28;
  localparam logic [7:0] A_LOAD = 8'h2C;
  localparam logic [7:0] A_KICK = 8'h30;
  localparam logic [7:0] A_STAT = 8'h34;
  localparam logic [7:0] A_CTRL = 8'h48;

  wdog_top i_wdog_top (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .wdt_rst_req (wdt_rst_req)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_we = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 20; i++) begin
      rd(A_STAT, s);
      if (s[4] == 1'b0) break;
      @(negedge clk);
    end
  endtask

  // Returns how far the counter moves over 5 cycles
  task automatic delta5(output logic [31:0] dlt);
    logic [31:0] a, b;
    rd(A_CNT, a);
    repeat (5) @(negedge clk);
    rd(A_CNT, b);
    dlt = b - a;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CNT, v);  check("R1 counter", v, 32'hFFFF_0000);
    rd(A_LOAD, v); check("R1 load", v, 32'hFFFF_0000);
    rd(A_STAT, v); check("R1 status", v, 32'h0);
    check("R1 rst_req", {31'b0, wdt_rst_req}, 32'h0);
  endtask

  task automatic t_count();
    logic [31:0] d;
    tick = 1'b1;
    delta5(d); check("R2 counts while enabled (R1 enabled)", d, 32'd5);
    tick = 1'b0;
    delta5(d); check("R2 holds without tick", d, 32'd0);
    tick = 1'b1;
  endtask

  task automatic t_pending_abort();
    logic [31:0] v, d;
    wr(A_CTRL, 32'h0000_AAAA);
    for (int i = 0; i < 4; i++) begin
      rd(A_STAT, v); check("R3 pending high", v, 32'h10);
      @(negedge clk);
    end
    rd(A_STAT, v); check("R3 pending cleared after 4", v, 32'h0);
    wr(A_CTRL, 32'h0000_1234);
    wait_idle();
    delta5(d); check("R5 abort keeps running", d, 32'd5);
    rd(A_CTRL, v); check("R10 control readback", v, 32'h0000_1234);
    wr(A_CTRL, 32'h0000_5555);
    wait_idle();
    delta5(d); check("R5 lone second word no effect", d, 32'd5);
  endtask

  task automatic t_drop_and_stop();
    logic [31:0] v, d;
    wr(A_CTRL, 32'h0000_AAAA);
    wr(A_CTRL, 32'h0000_5555);  // lands inside pending window
    wait_idle();
    delta5(d); check("R7 dropped write did not stop", d, 32'd5);
    rd(A_CTRL, v); check("R7 control value unchanged", v, 32'h0000_AAAA);
    wr(A_CTRL, 32'h0000_5555);
    wait_idle();
    delta5(d); check("R4 stopped counter holds", d, 32'd0);
  endtask

  task automatic t_restart();
    logic [31:0] v;
    wr(A_LOAD, 32'h0000_0100);
    rd(A_LOAD, v); check("R10 load readback", v, 32'h0000_0100);
    wr(A_CTRL, 32'h0000_BBBB);
    wait_idle();
    wr(A_CTRL, 32'h0000_4444);
    wait_idle();
    rd(A_CNT, v); check("R6 reload on restart", v, 32'h0000_0100);
    repeat (5) @(negedge clk);
    rd(A_CNT, v); check("R6 counting after restart", v, 32'h0000_0105);
  endtask

  task automatic t_kick();
    logic [31:0] v;
    repeat (3) @(negedge clk);
    wr(A_KICK, 32'h0);
    rd(A_CNT, v); check("R9 service reload", v, 32'h0000_0100);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    int n;
    wr(A_LOAD, 32'hFFFF_FFF0);
    wr(A_KICK, 32'h0);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      n++;
      if (wdt_rst_req) break;
    end
    check("R8 request after 16 ticks", n, 32'd16);
    rd(A_CNT, v); check("R8 reloaded", v, 32'hFFFF_FFF0);
    @(negedge clk);
    check("R8 request one cycle", {31'b0, wdt_rst_req}, 32'h0);
    rd(A_CNT, v); check("R8 continues counting", v, 32'hFFFF_FFF1);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(8'h40, 32'hDEAD_BEEF);
    rd(8'h40, v);  check("R10 unmapped read zero", v, 32'h0);
    rd(8'h00, v);  check("R10 offset 0 reads zero", v, 32'h0);
    rd(A_LOAD, v); check("R10 unmapped write ignored", v, 32'hFFFF_FFF0);
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_count();
    t_pending_abort();
    t_drop_and_stop();
    t_restart();
    t_kick();
    t_overflow();
    t_unmapped();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog timeout actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule